// File: doc/BRIEF.md
# Byte SPI Controller with Sequenced Status Flags

This block is a byte-wide serial peripheral controller for a CPU bus. It works as bus master (driving the serial clock and the master-out line) or as slave (following an external clock and chip select). Software reaches it through three registers: control, control/status and data. A transfer shifts one byte out most significant bit first while one byte shifts in. Clock idles low, receive is sampled on the rising edge and transmit data changes on the falling edge.

Four status flags are kept: transfer complete, write collision, overrun and mode fault. None of them is cleared by writing ones. Each clears only after a fixed sequence of register accesses, so software that services the flags in the usual order clears them as a side effect. While a completed byte has not been acknowledged, writes to the data register are dropped. This keeps a late write from starting a new transfer over unread data. The chip select used by the slave logic can come from the pin or from a software bit. An output-disable bit releases the data output line. One interrupt line reports completion and mode faults.

Top module: `spi_seq_ctrl`

## Requirements
- R1: After reset, the control register at address 0, the control/status register at address 1 and the data register at address 2 all read 0x00. The irq output is low, and sck_oe, mosi_oe and miso_oe are low.
- R2: The control register fields are: bit7 interrupt enable, bit6 enable, bit4 master select, bits1:0 divider d. When enable and master select are both 1, a write to the data register starts a master transfer. SCK idles low with a half period of 2^(d+1) clocks. MISO is sampled on each rising SCK edge. MOSI carries the byte MSB first and changes on falling edges. After the eighth falling edge, control/status bit7 is set and the received byte reads from address 2.
- R3: Control/status bit7 clears only after a control/status read taken while the flag is set, followed by any read or write of the data register. A data access with no such earlier read leaves the flag set.
- R4: While bit7 is set and no control/status read has followed it, a data register write is dropped: no transfer starts and no other flag changes.
- R5: A data register write during a transfer sets control/status bit6 and does not disturb the running byte. Bit6 clears through the same read-then-data-access sequence as bit7.
- R6: If a byte completes while bit7 is already set, control/status bit5 is set and the data register keeps the earlier byte. Bit5 clears on the next control/status read.
- R7: With enable set and master select clear, the block acts as slave while its select is low. It shifts the byte preloaded by a data write out on MISO and captures MOSI. It then sets bit7 with the received byte readable at address 2.
- R8: A low select level while enable and master select are set causes the following. Control/status bit4 is set. Control bits 6 and 4 are cleared, which drops sck_oe. Bit4 clears when a control register write follows a control register access that was taken while bit4 was set.
- R9: Control/status bit2 = 1 keeps mosi_oe and miso_oe low.
- R10: Control/status bit1 = 1 makes the pin ss_n_i be ignored, and control/status bit0 gives the select level instead (0 selected, 1 deselected).
- R11: Control/status bit3 always reads 0. Only bits 2:0 are software writable.
- R12: irq is high exactly when control bit7 is 1 and control/status bit7 or bit4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 control/status, 2 data |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out data seen in slave mode |
| mosi_o | output | 1 | Master-out data driven in master mode |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in data seen in master mode |
| miso_o | output | 1 | Master-in data driven in slave mode |
| miso_oe | output | 1 | Master-in output enable |
| ss_n_i | input | 1 | Select pin, active low |

## Verification
The assertions check several properties on every cycle. A completed byte always raises the completion flag. The completion flag cannot drop without an armed sequence. An overrun never alters the held byte. A blocked write never starts the shifter. A mode fault drops the clock drive in the same cycle. Output disable always keeps both data drivers off, the reserved status bit reads zero, and irq follows the enabled flags. Only the bench scenarios can show the rest: the shifted bit order and timing against an external device at each divider, the exact read/access orderings that do or do not clear each flag, slave transfers with preload, and chip-select override by software.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CSR  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // control register fields
  localparam int C_IE  = 7;
  localparam int C_EN  = 6;
  localparam int C_MST = 4;
  localparam logic [7:0] CTRL_MASK = 8'hD3;

  // control/status software fields
  localparam int S_OD  = 2;
  localparam int S_SSM = 1;
  localparam int S_SSI = 0;

  localparam int DIV_W  = 2;
  localparam int HCNT_W = 5;

  // clocks per SCK half period for a divider code
  function automatic logic [HCNT_W-1:0] half_period(input logic [DIV_W-1:0] div);
    return HCNT_W'(2) << div;
  endfunction

  // effective select level: 1 = deselected
  function automatic logic select_level(input logic ssm, input logic ssi, input logic pin_n);
    return ssm ? ssi : pin_n;
  endfunction

  function automatic logic irq_level(input logic ie, input logic done_f, input logic fault_f);
    return ie & (done_f | fault_f);
  endfunction

endpackage

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter
  import spi_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 mst,
  input  logic                 sel,
  input  logic [DIV_W-1:0]     div,
  input  logic                 start,
  input  logic [DATA_W-1:0]    ld_data,
  input  logic                 sck_i,
  input  logic                 mosi_i,
  input  logic                 miso_i,
  output logic                 sck_o,
  output logic                 sdo,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_W-1:0]    rx_data
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic [HCNT_W-1:0] hcnt;
  logic              rx_bit;
  logic              sck_q;
  logic              run;
  logic              mid;
  logic [2:0]        sck_sy;
  logic [1:0]        mosi_sy;

  logic s_rise, s_fall, m_tick, m_rise, m_fall;
  logic rise_ev, fall_ev, last, din;

  assign s_rise  = sck_sy[1] & ~sck_sy[2];
  assign s_fall  = ~sck_sy[1] & sck_sy[2];
  assign m_tick  = run && (hcnt == half_period(div) - HCNT_W'(1));
  assign m_rise  = m_tick & ~sck_q;
  assign m_fall  = m_tick & sck_q;
  assign rise_ev = mst ? m_rise : (en & sel & s_rise);
  assign fall_ev = mst ? m_fall : (en & sel & s_fall & mid);
  assign din     = mst ? miso_i : mosi_sy[1];
  assign last    = (cnt == LAST_BIT);
  assign done    = fall_ev & last;
  assign rx_data = {shreg[DATA_W-2:0], rx_bit};

  assign sck_o = sck_q;
  assign sdo   = shreg[DATA_W-1];
  assign busy  = mst ? run : (mid | (cnt != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      mosi_sy <= '0;
    end else begin
      sck_sy  <= {sck_sy[1:0], sck_i};
      mosi_sy <= {mosi_sy[0], mosi_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      cnt    <= '0;
      hcnt   <= '0;
      rx_bit <= 1'b0;
      sck_q  <= 1'b0;
      run    <= 1'b0;
      mid    <= 1'b0;
    end else if (start) begin
      shreg <= ld_data;
      cnt   <= '0;
      hcnt  <= '0;
      sck_q <= 1'b0;
      mid   <= 1'b0;
      run   <= en & mst;
    end else begin
      if (run) hcnt <= m_tick ? '0 : hcnt + HCNT_W'(1);
      if (m_tick) sck_q <= ~sck_q;
      if (rise_ev) begin
        rx_bit <= din;
        mid    <= 1'b1;
      end
      if (fall_ev) begin
        shreg <= rx_data;
        mid   <= 1'b0;
        cnt   <= last ? '0 : cnt + CNT_W'(1);
        if (last) run <= 1'b0;
      end
      // slave deselected or block disabled: drop a partial byte
      if (!en || (!mst && !sel)) begin
        cnt <= '0;
        mid <= 1'b0;
      end
      if (!en || !mst) begin
        run   <= 1'b0;
        sck_q <= 1'b0;
        hcnt  <= '0;
      end
    end
  end

endmodule

// File: rtl/spi_seq_flags.sv
module spi_seq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_done,
  input  logic evt_wcol,
  input  logic evt_modf,
  input  logic csr_rd,
  input  logic data_acc,
  input  logic ctrl_acc,
  input  logic ctrl_wr,
  output logic flag_sf,
  output logic flag_wc,
  output logic flag_ov,
  output logic flag_mf,
  output logic seq_armed,
  output logic evt_ovr
);

  logic mf_armed;

  assign evt_ovr = evt_done & flag_sf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_sf   <= 1'b0;
      flag_wc   <= 1'b0;
      flag_ov   <= 1'b0;
      flag_mf   <= 1'b0;
      seq_armed <= 1'b0;
      mf_armed  <= 1'b0;
    end else begin
      // completion / collision: status read arms, data access clears
      if (data_acc && seq_armed) begin
        flag_sf   <= 1'b0;
        flag_wc   <= 1'b0;
        seq_armed <= 1'b0;
      end else if (csr_rd && (flag_sf || flag_wc)) begin
        seq_armed <= 1'b1;
      end
      if (evt_done) flag_sf <= 1'b1;
      if (evt_wcol) flag_wc <= 1'b1;

      // overrun: any status read clears
      if (csr_rd)  flag_ov <= 1'b0;
      if (evt_ovr) flag_ov <= 1'b1;

      // mode fault: control access arms, later control write clears
      if (ctrl_wr && mf_armed) begin
        flag_mf  <= 1'b0;
        mf_armed <= 1'b0;
      end else if (ctrl_acc && flag_mf) begin
        mf_armed <= 1'b1;
      end
      if (evt_modf) flag_mf <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ss_n_i
);

  logic [7:0]        ctrl_q;
  logic [2:0]        csr_sw;
  logic [DATA_W-1:0] rx_buf;
  logic [1:0]        ss_sy;

  logic ctrl_ie, ctrl_en, ctrl_mst, csr_od;
  logic ss_lvl, slave_sel;
  logic rd_any, wr_any, csr_rd, csr_wr, data_acc, data_wr, ctrl_acc, ctrl_wr;
  logic wr_blocked, start, evt_wcol, evt_modf;
  logic xfer_busy, evt_done, evt_ovr, sdo;
  logic flag_sf, flag_wc, flag_ov, flag_mf, seq_armed;
  logic [DATA_W-1:0] rx_data;

  assign ctrl_ie  = ctrl_q[C_IE];
  assign ctrl_en  = ctrl_q[C_EN];
  assign ctrl_mst = ctrl_q[C_MST];
  assign csr_od   = csr_sw[S_OD];

  assign ss_lvl    = select_level(csr_sw[S_SSM], csr_sw[S_SSI], ss_sy[1]);
  assign slave_sel = ~ss_lvl;

  assign rd_any   = bus_sel & ~bus_we;
  assign wr_any   = bus_sel & bus_we;
  assign csr_rd   = rd_any & (bus_addr == ADDR_CSR);
  assign csr_wr   = wr_any & (bus_addr == ADDR_CSR);
  assign data_acc = bus_sel & (bus_addr == ADDR_DATA);
  assign data_wr  = wr_any & (bus_addr == ADDR_DATA);
  assign ctrl_acc = bus_sel & (bus_addr == ADDR_CTRL);
  assign ctrl_wr  = wr_any & (bus_addr == ADDR_CTRL);

  assign wr_blocked = flag_sf & ~seq_armed;
  assign start      = data_wr & ~wr_blocked & ~xfer_busy;
  assign evt_wcol   = data_wr & ~wr_blocked & xfer_busy;
  assign evt_modf   = ctrl_en & ctrl_mst & ~ss_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_sy <= 2'b11;
    end else begin
      ss_sy <= {ss_sy[0], ss_n_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      csr_sw <= '0;
      rx_buf <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata[7:0] & CTRL_MASK;
      if (evt_modf) begin
        ctrl_q[C_EN]  <= 1'b0;
        ctrl_q[C_MST] <= 1'b0;
      end
      if (csr_wr) csr_sw <= bus_wdata[2:0];
      if (evt_done && !flag_sf) rx_buf <= rx_data;
    end
  end

  spi_seq_shifter #(.DATA_W(DATA_W)) shifter_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl_en),
    .mst     (ctrl_mst),
    .sel     (slave_sel),
    .div     (ctrl_q[DIV_W-1:0]),
    .start   (start),
    .ld_data (bus_wdata),
    .sck_i   (sck_i),
    .mosi_i  (mosi_i),
    .miso_i  (miso_i),
    .sck_o   (sck_o),
    .sdo     (sdo),
    .busy    (xfer_busy),
    .done    (evt_done),
    .rx_data (rx_data)
  );

  spi_seq_flags flags_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_done  (evt_done),
    .evt_wcol  (evt_wcol),
    .evt_modf  (evt_modf),
    .csr_rd    (csr_rd),
    .data_acc  (data_acc),
    .ctrl_acc  (ctrl_acc),
    .ctrl_wr   (ctrl_wr),
    .flag_sf   (flag_sf),
    .flag_wc   (flag_wc),
    .flag_ov   (flag_ov),
    .flag_mf   (flag_mf),
    .seq_armed (seq_armed),
    .evt_ovr   (evt_ovr)
  );

  assign irq     = irq_level(ctrl_ie, flag_sf, flag_mf);
  assign sck_oe  = ctrl_en & ctrl_mst;
  assign mosi_oe = ctrl_en & ctrl_mst & ~csr_od;
  assign miso_oe = ctrl_en & ~ctrl_mst & ~csr_od & slave_sel;
  assign mosi_o  = sdo;
  assign miso_o  = sdo;

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = DATA_W'(ctrl_q);
      ADDR_CSR:  bus_rdata = DATA_W'({flag_sf, flag_wc, flag_ov, flag_mf, 1'b0, csr_sw});
      ADDR_DATA: bus_rdata = rx_buf;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_seq_ctrl_chk.sv
module spi_seq_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              sck_oe,
  input logic              mosi_oe,
  input logic              miso_oe,
  input logic              ctrl_ie,
  input logic              csr_od,
  input logic              flag_sf,
  input logic              flag_mf,
  input logic              seq_armed,
  input logic              data_wr,
  input logic              xfer_busy,
  input logic              evt_done,
  input logic              evt_ovr,
  input logic [DATA_W-1:0] rx_buf
);

  // R2
  done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> flag_sf);

  // R3
  no_unarmed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_sf && !seq_armed) |=> flag_sf);

  // R4
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && flag_sf && !seq_armed && !xfer_busy && sck_oe) |=> !xfer_busy);

  // R6
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovr |=> $stable(rx_buf));

  // R8
  fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_mf) |-> !sck_oe);

  // R9
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_od |-> (!mosi_oe && !miso_oe));

  // R11
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == 2'd1) |-> !bus_rdata[3]);

  // R12
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_ie && (flag_sf || flag_mf)) |-> irq);

  // R12
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_sf && !flag_mf) |-> !irq);

endmodule

bind spi_seq_ctrl spi_seq_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .sck_oe    (sck_oe),
  .mosi_oe   (mosi_oe),
  .miso_oe   (miso_oe),
  .ctrl_ie   (ctrl_ie),
  .csr_od    (csr_od),
  .flag_sf   (flag_sf),
  .flag_mf   (flag_mf),
  .seq_armed (seq_armed),
  .data_wr   (data_wr),
  .xfer_busy (xfer_busy),
  .evt_done  (evt_done),
  .evt_ovr   (evt_ovr),
  .rx_buf    (rx_buf)
);

// File: tb/spi_seq_ctrl_tb_top.sv
module spi_seq_ctrl_tb_top;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CSR  = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam int NVEC = 4;
  localparam logic [7:0] VTX  [NVEC] = '{8'hA5, 8'h3C, 8'hF0, 8'h01};
  localparam logic [7:0] VEXT [NVEC] = '{8'h5A, 8'hC7, 8'h0F, 8'h80};
  localparam logic [1:0] VDIV [NVEC] = '{2'd0, 2'd1, 2'd3, 2'd2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic tb_sck = 1'b0, tb_mosi = 1'b0, ss_n = 1'b1;

  // external slave model for master-mode transfers
  logic [7:0] ext_tx = 8'h00;
  logic [7:0] ext_rx = 8'h00;
  logic [2:0] ext_cnt = 3'd0;
  logic [2:0] ext_base = 3'd0;
  logic [2:0] ext_idx;
  logic tb_miso;
  assign ext_idx = ext_cnt - ext_base;
  assign tb_miso = ext_tx[~ext_idx];
  always @(posedge sck_o) ext_rx <= {ext_rx[6:0], mosi_o};
  always @(negedge sck_o) ext_cnt <= ext_cnt + 3'd1;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  spi_seq_ctrl #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sck_i(tb_sck), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(tb_mosi), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(tb_miso), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] d;
    bus_rd(a, d);
    chk(req, d, exp);
  endtask

  // act as external master towards the block in slave mode
  task automatic slave_xfer(input logic [7:0] b, output logic [7:0] got);
    ss_n = 1'b0;
    tick(6);
    for (int i = 7; i >= 0; i--) begin
      tb_mosi = b[i];
      tick(6);
      got = {got[6:0], miso_o};
      tb_sck = 1'b1;
      tick(6);
      tb_sck = 1'b0;
    end
    tick(6);
    ss_n = 1'b1;
    tick(4);
  endtask

  initial begin
    #(8 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int toggles;
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    rd_chk("R1 ctrl", A_CTRL, 8'h00);
    rd_chk("R1 csr", A_CSR, 8'h00);
    rd_chk("R1 data", A_DATA, 8'h00);
    chk("R1 irq/oe", {4'h0, irq, sck_oe, mosi_oe, miso_oe}, 8'h00);

    // R2 R3 R12 master transfers from the vector table
    for (int v = 0; v < NVEC; v++) begin
      bus_wr(A_CTRL, 8'hD0 | {6'd0, VDIV[v]});
      ext_tx = VEXT[v];
      ext_base = ext_cnt;
      bus_wr(A_DATA, VTX[v]);
      tick((16 << VDIV[v]) * 2 + 12);
      chk("R12 irq on completion", {7'd0, irq}, 8'h01);
      rd_chk("R2 csr complete", A_CSR, 8'h80);
      rd_chk("R2 received byte", A_DATA, VEXT[v]);
      chk("R2 byte seen by slave", ext_rx, VTX[v]);
      rd_chk("R3 flag cleared", A_CSR, 8'h00);
      chk("R12 irq cleared", {7'd0, irq}, 8'h00);
    end

    // R3 R4: data access without status read, blocked write
    bus_wr(A_CTRL, 8'hD0);
    ext_tx = 8'h7E;
    ext_base = ext_cnt;
    bus_wr(A_DATA, 8'h81);
    tick(50);
    rd_chk("R3 data read alone", A_DATA, 8'h7E);
    bus_wr(A_DATA, 8'h55);
    toggles = 0;
    for (int i = 0; i < 40; i++) begin
      logic prev;
      prev = sck_o;
      @(negedge clk);
      if (sck_o != prev) toggles++;
    end
    chk("R4 no transfer after blocked write", 8'(toggles), 8'h00);
    rd_chk("R3 R4 flag still set, no collision", A_CSR, 8'h80);
    rd_chk("R4 data unchanged", A_DATA, 8'h7E);
    rd_chk("R3 cleared by sequence", A_CSR, 8'h00);

    // R5 write collision
    bus_wr(A_CTRL, 8'hD2);
    ext_tx = 8'h99;
    ext_base = ext_cnt;
    bus_wr(A_DATA, 8'h3C);
    tick(20);
    bus_wr(A_DATA, 8'hFF);
    tick(150);
    rd_chk("R5 collision flag", A_CSR, 8'hC0);
    chk("R5 running byte intact", ext_rx, 8'h3C);
    rd_chk("R5 received byte", A_DATA, 8'h99);
    rd_chk("R5 collision cleared", A_CSR, 8'h00);

    // R9 output disable
    bus_wr(A_CSR, 8'h04);
    chk("R9 mosi released", {6'd0, sck_oe, mosi_oe}, 8'h02);
    bus_wr(A_CSR, 8'h00);
    chk("R9 mosi driven again", {7'd0, mosi_oe}, 8'h01);

    // R11 reserved bit
    bus_wr(A_CSR, 8'hFF);
    rd_chk("R11 reserved reads zero", A_CSR, 8'h07);
    bus_wr(A_CSR, 8'h00);

    // R10 software select in master mode suppresses fault
    bus_wr(A_CSR, 8'h03);
    ss_n = 1'b0;
    tick(6);
    rd_chk("R10 pin ignored, no fault", A_CSR, 8'h03);
    ss_n = 1'b1;
    bus_wr(A_CSR, 8'h00);

    // R8 mode fault
    bus_wr(A_CTRL, 8'hD0);
    ss_n = 1'b0;
    tick(6);
    chk("R8 sck released", {7'd0, sck_oe}, 8'h00);
    chk("R12 irq on fault", {7'd0, irq}, 8'h01);
    rd_chk("R8 fault flag", A_CSR, 8'h10);
    rd_chk("R8 ctrl demoted", A_CTRL, 8'h80);
    ss_n = 1'b1;
    tick(4);
    rd_chk("R8 flag held before write", A_CSR, 8'h10);
    bus_wr(A_CTRL, 8'h00);
    rd_chk("R8 fault cleared", A_CSR, 8'h00);

    // R7 slave transfer
    bus_wr(A_CTRL, 8'h40);
    bus_wr(A_DATA, 8'h5A);
    slave_xfer(8'hC3, got);
    chk("R7 slave shifted preload", got, 8'h5A);
    rd_chk("R7 slave complete", A_CSR, 8'h80);
    rd_chk("R7 slave received", A_DATA, 8'hC3);
    rd_chk("R7 slave cleared", A_CSR, 8'h00);

    // R10 software select in slave mode
    bus_wr(A_CSR, 8'h03);
    ss_n = 1'b0;
    tick(6);
    chk("R10 deselected by bit", {7'd0, miso_oe}, 8'h00);
    bus_wr(A_CSR, 8'h02);
    ss_n = 1'b1;
    tick(6);
    chk("R10 selected by bit", {7'd0, miso_oe}, 8'h01);
    bus_wr(A_CSR, 8'h00);

    // R6 overrun
    slave_xfer(8'h11, got);
    slave_xfer(8'h22, got);
    rd_chk("R6 overrun flagged", A_CSR, 8'hA0);
    rd_chk("R6 overrun cleared by read", A_CSR, 8'h80);
    rd_chk("R6 earlier byte kept", A_DATA, 8'h11);
    rd_chk("R6 completion cleared", A_CSR, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule